// File: doc/BRIEF.md
# Shared-Line Serial Driver for a DAC and an Output Latch Register

This block lets one host feed two serial peripherals over a single clock wire and a single data wire. One peripheral is a 16-bit converter that listens only while its active-low select is held down and that updates its analog output when its active-low load input is pulsed. The other is an 8-bit serial-in register whose outputs take the shifted byte only on a rising edge of its storage strobe. The second device has no select input. It ignores traffic meant for the converter because its outputs hold until that strobe.

The host offers a converter word or a register byte on two separate valid/ready ports. The block accepts one request at a time and sends it most significant bit first. It frames the converter word with the select line, and then fires the latch event that belongs to the device just written. The serial clock comes from the system clock through a half-period divider. The converter load pulse length is computed from the system clock period and a minimum width in nanoseconds. Converter requests win when both ports are valid together, so a steady stream of converter samples is not held up. A pending register byte stays offered and is sent in the first idle cycle with no converter request.

Top module: `shared_ser_drv`

## Requirements
- R1: While reset is asserted, and in the first idle cycles after it, sclk and sdata are 0, dac_cs_n and dac_ld_n are 1, sr_latch is 0, and both ready outputs are 1 (sr_ready only while dac_valid is 0).
- R2: A converter request accepted on a clock edge holds dac_cs_n low from the next cycle for exactly 16 × 2 × HALF_DIV cycles, without a break, and then drives it high.
- R3: Bits leave on sdata most significant first. Bit k, counted from 0 at the MSB, is present for the 2 × HALF_DIV cycles of its bit slot. sdata changes only at a slot boundary, never while sclk is high, and is 0 outside the bit slots.
- R4: In each bit slot sclk is low for HALF_DIV cycles and then high for HALF_DIV cycles. Outside the slots it is low. With defaults this gives 12.5 MHz from a 100 MHz clock.
- R5: After a converter frame, dac_cs_n is high for one cycle with dac_ld_n still high. dac_ld_n is then low for exactly ceil(LD_MIN_NS / CLK_NS) cycles (10 with defaults), with dac_cs_n high the whole time.
- R6: A register transfer sends 8 bits in 8 × 2 × HALF_DIV cycles. During it, and during its latch phase, dac_cs_n and dac_ld_n stay high.
- R7: sr_latch rises one cycle after the last register bit slot and stays high for SR_LAT_CYC cycles. It never rises after a converter frame.
- R8: dac_ready is high only while the block is idle. A request is taken on an edge where its valid and ready are both 1. While busy, both ready outputs are 0.
- R9: When both valid inputs are high in an idle cycle, the converter word is taken and sr_ready is 0. A register byte held valid is always sent once the converter requests stop, and it is never lost.
- R10: After each latch phase the block spends at least one idle cycle, with all lines at their idle levels, before the next frame begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dac_valid | input | 1 | Converter word offered |
| dac_data | input | 16 | Converter word |
| dac_ready | output | 1 | Converter word can be taken this cycle |
| sr_valid | input | 1 | Register byte offered |
| sr_data | input | 8 | Register byte |
| sr_ready | output | 1 | Register byte can be taken this cycle |
| sclk | output | 1 | Shared serial clock, idles low |
| sdata | output | 1 | Shared serial data, MSB first |
| dac_cs_n | output | 1 | Converter select, active low |
| dac_ld_n | output | 1 | Converter load strobe, active low |
| sr_latch | output | 1 | Register storage strobe, active high |

## Verification
The hardest case to reach is the priority decision in an idle cycle where a register byte has waited through a whole converter frame and a new converter word is already offered. That cycle is the only one that shows whether the byte is held back, and later sent, rather than dropped or merged. The stimulus starts a register request and two converter requests in the same cycle. The converter driver raises its second request as soon as the first is accepted, so the idle cycle after the first load pulse sees both valids high. A behavioural model predicts every output in every cycle, including the single idle gap and the point where the register byte finally goes out.

// File: rtl/ssd_pkg.sv
package ssd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_POST,
    ST_LATCH
  } ssd_state_e;

  // Smallest whole number of cycles covering num units at den units per cycle
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ssd_tick.sv
// Bit-slot timer: low half then high half of the serial clock per slot
module ssd_tick #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk_lvl,
  output logic bit_end
);
  localparam int SLOT = 2 * HALF_DIV;
  localparam int PW   = (SLOT > 1) ? $clog2(SLOT) : 1;

  logic [PW-1:0] phase;

  assign bit_end  = run && (phase == PW'(SLOT - 1));
  assign sclk_lvl = run && (phase >= PW'(HALF_DIV));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                phase <= '0;
    else if (!run || bit_end)  phase <= '0;
    else                       phase <= phase + 1'b1;
  end
endmodule

// File: rtl/ssd_shift.sv
// Left-shifting word register; the MSB drives the data line
module ssd_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] shreg;

  assign msb = shreg[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     shreg <= '0;
    else if (load)  shreg <= load_word;
    else if (shift) shreg <= {shreg[W-2:0], 1'b0};
  end
endmodule

// File: rtl/ssd_seq.sv
// Transfer sequencer: arbitration, bit count and latch-phase timing
module ssd_seq
  import ssd_pkg::*;
#(
  parameter int DAC_W      = 16,
  parameter int SR_W       = 8,
  parameter int LD_CYC     = 10,
  parameter int SR_LAT_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dac_valid,
  input  logic sr_valid,
  input  logic bit_end,
  output logic idle,
  output logic in_shift,
  output logic in_latch,
  output logic dev_dac,
  output logic dac_take,
  output logic sr_take,
  output logic last_bit
);
  localparam int BW = $clog2(DAC_W + 1);
  localparam int LW = $clog2(max2(LD_CYC, SR_LAT_CYC) + 1);

  ssd_state_e    st;
  logic [BW-1:0] bits_left;
  logic [LW-1:0] lat_cnt;

  assign idle     = (st == ST_IDLE);
  assign in_shift = (st == ST_SHIFT);
  assign in_latch = (st == ST_LATCH);
  assign dac_take = idle && dac_valid;
  assign sr_take  = idle && sr_valid && !dac_valid;
  assign last_bit = bit_end && (bits_left == BW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      dev_dac   <= 1'b0;
      bits_left <= '0;
      lat_cnt   <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (dac_take) begin
            st        <= ST_SHIFT;
            dev_dac   <= 1'b1;
            bits_left <= BW'(DAC_W);
          end else if (sr_take) begin
            st        <= ST_SHIFT;
            dev_dac   <= 1'b0;
            bits_left <= BW'(SR_W);
          end
        end
        ST_SHIFT: begin
          if (bit_end) begin
            bits_left <= bits_left - 1'b1;
            if (last_bit) st <= ST_POST;
          end
        end
        ST_POST: begin
          st      <= ST_LATCH;
          lat_cnt <= dev_dac ? LW'(LD_CYC - 1) : LW'(SR_LAT_CYC - 1);
        end
        ST_LATCH: begin
          if (lat_cnt == '0) st <= ST_IDLE;
          else               lat_cnt <= lat_cnt - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/shared_ser_drv.sv
module shared_ser_drv
  import ssd_pkg::*;
#(
  parameter int DAC_W      = 16,
  parameter int SR_W       = 8,
  parameter int HALF_DIV   = 4,
  parameter int CLK_NS     = 10,
  parameter int LD_MIN_NS  = 100,
  parameter int SR_LAT_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dac_valid,
  input  logic [DAC_W-1:0] dac_data,
  output logic             dac_ready,
  input  logic             sr_valid,
  input  logic [SR_W-1:0]  sr_data,
  output logic             sr_ready,
  output logic             sclk,
  output logic             sdata,
  output logic             dac_cs_n,
  output logic             dac_ld_n,
  output logic             sr_latch
);
  localparam int LD_CYC = ceil_div(LD_MIN_NS, CLK_NS);

  // Named internal events, visible to the bound checker
  logic idle, in_shift, in_latch, dev_dac;
  logic dac_take, sr_take, last_bit, bit_end, sclk_lvl, msb;
  logic [DAC_W-1:0] load_word;

  assign load_word = dac_take ? dac_data
                              : (DAC_W'(sr_data) << (DAC_W - SR_W));

  ssd_seq #(
    .DAC_W(DAC_W), .SR_W(SR_W), .LD_CYC(LD_CYC), .SR_LAT_CYC(SR_LAT_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .dac_valid(dac_valid), .sr_valid(sr_valid),
    .bit_end(bit_end), .idle(idle), .in_shift(in_shift), .in_latch(in_latch),
    .dev_dac(dev_dac), .dac_take(dac_take), .sr_take(sr_take),
    .last_bit(last_bit)
  );

  ssd_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(in_shift),
    .sclk_lvl(sclk_lvl), .bit_end(bit_end)
  );

  ssd_shift #(.W(DAC_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(dac_take || sr_take),
    .load_word(load_word), .shift(bit_end), .msb(msb)
  );

  assign sclk      = sclk_lvl;
  assign sdata     = msb;
  assign dac_cs_n  = !(in_shift && dev_dac);
  assign dac_ld_n  = !(in_latch && dev_dac);
  assign sr_latch  = in_latch && !dev_dac;
  assign dac_ready = idle;
  assign sr_ready  = idle && !dac_valid;
endmodule

// File: rtl/ssd_chk.sv
module ssd_chk #(
  parameter int CLK_NS    = 10,
  parameter int LD_MIN_NS = 100
) (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic sdata,
  input logic dac_cs_n,
  input logic dac_ld_n,
  input logic sr_latch,
  input logic dac_valid,
  input logic dac_ready,
  input logic sr_ready,
  input logic bit_end
);
  localparam int MIN_CYC = (LD_MIN_NS + CLK_NS - 1) / CLK_NS;

  logic [15:0] ld_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ld_run <= '0;
    else if (!dac_ld_n) ld_run <= ld_run + 1'b1;
    else                ld_run <= '0;
  end

  // R3
  data_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(sdata));

  // R4
  slot_end_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |-> sclk);

  // R2
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_cs_n) |-> !sclk && dac_ld_n && !sr_latch);

  // R5
  ld_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_ld_n) |-> dac_cs_n && $past(dac_cs_n));

  // R5
  ld_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_ld_n) |-> ld_run == 16'(MIN_CYC));

  // R7
  sr_latch_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_latch) |-> dac_cs_n && dac_ld_n && !sclk);

  // R8
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_valid && dac_ready) |=> !dac_ready && !sr_ready);

  // R9
  dac_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_valid && dac_ready) |-> !sr_ready);

  // R10
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_ready |-> !sclk && dac_cs_n && dac_ld_n && !sr_latch);
endmodule

bind shared_ser_drv ssd_chk i_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata),
  .dac_cs_n(dac_cs_n), .dac_ld_n(dac_ld_n), .sr_latch(sr_latch),
  .dac_valid(dac_valid), .dac_ready(dac_ready), .sr_ready(sr_ready),
  .bit_end(bit_end)
);

// File: tb/test_shared_ser_drv.sv
`timescale 1ns/1ps
module test_shared_ser_drv;
  localparam int HD  = 4;   // half slot in cycles
  localparam int LDL = 10;  // 100 ns at 10 ns per cycle
  localparam int SRL = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dac_valid = 1'b0, sr_valid = 1'b0;
  logic [15:0] dac_data = '0;
  logic [7:0]  sr_data = '0;
  logic dac_ready, sr_ready, sclk, sdata, dac_cs_n, dac_ld_n, sr_latch;

  always #5 clk = ~clk;

  shared_ser_drv i_shared_ser_drv (
    .clk(clk), .rst_n(rst_n), .dac_valid(dac_valid), .dac_data(dac_data),
    .dac_ready(dac_ready), .sr_valid(sr_valid), .sr_data(sr_data),
    .sr_ready(sr_ready), .sclk(sclk), .sdata(sdata), .dac_cs_n(dac_cs_n),
    .dac_ld_n(dac_ld_n), .sr_latch(sr_latch)
  );

  int vectors = 0, miscomp = 0;
  int dac_acc = 0, sr_acc = 0, dac_sent = 0, sr_sent = 0;

  // Reference model state
  bit          m_busy = 0, m_dev = 0, m_after = 0;
  int          m_t = 0;
  logic [15:0] m_word = '0;

  function automatic int frame_len(bit dev);
    return (dev ? 16 : 8) * 2 * HD;
  endfunction

  function automatic int latch_len(bit dev);
    return dev ? LDL : SRL;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_t = 0;
    end else if (m_busy) begin
      if (m_t == frame_len(m_dev) + latch_len(m_dev)) begin
        m_busy = 0; m_after = 1;
      end else m_t++;
    end else if (dac_valid) begin
      m_busy = 1; m_dev = 1; m_word = dac_data; m_t = 0; dac_acc++;
    end else if (sr_valid) begin
      m_busy = 1; m_dev = 0; m_word = {8'h00, sr_data}; m_t = 0; sr_acc++;
    end
  end

  task automatic chk(input string tag, input string nm, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscomp++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(tag, "sclk", sclk, 1'b0);
    chk(tag, "sdata", sdata, 1'b0);
    chk(tag, "dac_cs_n", dac_cs_n, 1'b1);
    chk(tag, "dac_ld_n", dac_ld_n, 1'b1);
    chk(tag, "sr_latch", sr_latch, 1'b0);
    chk((tag == "R1") ? "R1" : "R8", "dac_ready", dac_ready, 1'b1);
    chk(dac_valid ? "R9" : ((tag == "R1") ? "R1" : "R8"), "sr_ready", sr_ready, !dac_valid);
  endtask

  // Compare against the model on every falling edge
  always @(negedge clk) begin
    if (!rst_n) chk_idle("R1");
    else if (!m_busy) chk_idle(m_after ? "R10" : "R1");
    else begin
      int n, s, b;
      n = m_dev ? 16 : 8;
      s = frame_len(m_dev);
      chk("R8", "dac_ready", dac_ready, 1'b0);
      chk("R8", "sr_ready", sr_ready, 1'b0);
      if (m_t < s) begin
        b = m_t / (2 * HD);
        chk("R4", "sclk", sclk, (m_t % (2 * HD)) >= HD);
        chk("R3", "sdata", sdata, m_word[n - 1 - b]);
        chk(m_dev ? "R2" : "R6", "dac_cs_n", dac_cs_n, !m_dev);
        chk(m_dev ? "R5" : "R6", "dac_ld_n", dac_ld_n, 1'b1);
        chk("R7", "sr_latch", sr_latch, 1'b0);
      end else begin
        chk("R4", "sclk", sclk, 1'b0);
        chk("R3", "sdata", sdata, 1'b0);
        chk(m_dev ? "R5" : "R6", "dac_cs_n", dac_cs_n, 1'b1);
        chk(m_dev ? "R5" : "R6", "dac_ld_n", dac_ld_n, !(m_dev && m_t > s));
        chk("R7", "sr_latch", sr_latch, !m_dev && m_t > s);
      end
    end
  end

  task automatic send_dac(input logic [15:0] w);
    int c;
    c = dac_acc;
    @(posedge clk); #1;
    dac_valid = 1'b1; dac_data = w; dac_sent++;
    wait (dac_acc != c);
    #1 dac_valid = 1'b0;
  endtask

  task automatic send_sr(input logic [7:0] w);
    int c;
    c = sr_acc;
    @(posedge clk); #1;
    sr_valid = 1'b1; sr_data = w; sr_sent++;
    wait (sr_acc != c);
    #1 sr_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (200) @(posedge clk);
  endtask

  task automatic run_all();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R2 R3 R5: converter words with varied bit patterns
    send_dac(16'hA5C3); settle();
    send_dac(16'h8001); settle();
    // R6 R7: register bytes at the edges of the value range
    send_sr(8'h80); settle();
    send_sr(8'hFF); settle();
    // R10: back-to-back converter words
    send_dac(16'hFFFF); send_dac(16'h0000); settle();
    // R9: register byte competing with two converter words
    fork
      send_sr(8'h3C);
      begin send_dac(16'h1234); send_dac(16'h5AF0); end
    join
    settle();
    send_sr(8'h01); send_dac(16'h7FFE); settle();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        miscomp++;
        $display("FAIL R8 watchdog actual=hung expected=done");
      end
    join_any
    disable fork;
    // R9: every offered request was taken exactly once
    vectors++;
    if (sr_acc != sr_sent) begin
      miscomp++;
      $display("FAIL R9 register requests served actual=%0d expected=%0d", sr_acc, sr_sent);
    end
    vectors++;
    if (dac_acc != dac_sent) begin
      miscomp++;
      $display("FAIL R8 converter requests served actual=%0d expected=%0d", dac_acc, dac_sent);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end
endmodule